// File: doc/BRIEF.md
# SHA-2 Message Schedule Expander

This block turns one padded message block into the stream of schedule words that a SHA-2 compression round consumes. It takes the block as sixteen words in one strobe and presents the first word at once. Each round-advance strobe then steps the output to the next schedule word. The first sixteen words come straight from the block. Every later word is derived from four older words through the two small sigma functions and a modular sum.

One datapath serves both family widths. In narrow mode (SHA-256) it works on 32-bit words and runs 64 rounds. In wide mode (SHA-512) it works on 64-bit words and runs 80 rounds. The rotate and shift amounts follow the selected mode. The mode is captured when the block is loaded. Storage is a sixteen-word sliding window: each advance pushes in the freshly computed word and discards the oldest one. Once the final word of a block is on the output, it stays there until the next load.

Top module: `sha2x_sched_expander`

## Requirements
- R1: After reset, `word_o` is zero and `last_o` is low, and `adv_i` has no effect until the first load.
- R2: The cycle after `load_i`, `word_o` shows block word 0. Block word k occupies `block_i[64k+63:64k]`. When `mode_i` was 0 at load (narrow mode), only the low 32 bits of each word are used, and `word_o[63:32]` reads zero for the whole block.
- R3: The cycle after each accepted `adv_i`, `word_o` shows the next schedule word W_{j+1}. In a cycle with neither `load_i` nor `adv_i`, `word_o` and `last_o` hold.
- R4: For j of 16 and above, W_j = s1(W_{j-2}) + W_{j-7} + s0(W_{j-15}) + W_{j-16}, with the sum taken modulo 2^32 in narrow mode and modulo 2^64 in wide mode.
- R5: Narrow mode (`mode_i`=0) uses s0(x) = ROTR7 ^ ROTR18 ^ SHR3 and s1(x) = ROTR17 ^ ROTR19 ^ SHR10 on 32-bit words.
- R6: Wide mode (`mode_i`=1) uses s0(x) = ROTR1 ^ ROTR8 ^ SHR7 and s1(x) = ROTR19 ^ ROTR61 ^ SHR6 on 64-bit words.
- R7: A block yields 64 words in narrow mode and 80 in wide mode. `last_o` is high exactly while `word_o` shows the final word. Further advances are ignored, and the final word is held until the next load.
- R8: The mode is sampled only at load. Changes on `mode_i` while a block is streaming do not alter the words produced or the round count.
- R9: `load_i` takes priority over `adv_i`. A load in any cycle, including mid-block or after the last word, restarts the stream at W_0 of the new block and clears `last_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_i | input | 1 | 0 = 32-bit words, 64 rounds; 1 = 64-bit words, 80 rounds; sampled at load |
| load_i | input | 1 | Block-load strobe |
| block_i | input | 1024 | Sixteen block words, word k in bits 64k+63..64k |
| adv_i | input | 1 | Round-advance strobe |
| word_o | output | 64 | Current schedule word (upper half zero in narrow mode) |
| last_o | output | 1 | High while `word_o` carries the final word of the block |

## Verification
The bench builds the block with its default parameters: a 64-bit lane, a sixteen-word window, and round limits of 64 and 80. With these defaults, every word of a full schedule in both modes can be compared against an independent model, and both round limits and the hold after the last word are reached within a few hundred cycles. The table rows mix seeds of all ones, high-bit and mixed patterns, and add idle gaps. Directed runs cover a mode flip mid-stream, a load colliding with an advance, and a reload from the held final word.

// File: rtl/sha2x_pkg.sv
`timescale 1ns/1ps
package sha2x_pkg;
    localparam int WIDE_W     = 64;
    localparam int NARROW_W   = WIDE_W / 2;
    localparam int WIN_D      = 16;
    localparam int RND_NARROW = 64;
    localparam int RND_WIDE   = 80;
    localparam int CNT_W      = $clog2(RND_WIDE);
    localparam int BLK_W      = WIN_D * WIDE_W;
    // window taps relative to the oldest entry
    localparam int TAP_S0     = 1;
    localparam int TAP_MID    = WIN_D - 7;
    localparam int TAP_S1     = WIN_D - 2;

    typedef logic [WIDE_W-1:0]   word_t;
    typedef logic [NARROW_W-1:0] half_t;

    typedef struct packed {
        word_t [WIN_D-1:0]  win;
        logic [CNT_W-1:0]   cnt;
        logic               active;
        logic               wide;
    } sched_st_t;

    function automatic half_t rotr_n(half_t x, int unsigned n);
        return (x >> n) | (x << (NARROW_W - n));
    endfunction

    function automatic word_t rotr_w(word_t x, int unsigned n);
        return (x >> n) | (x << (WIDE_W - n));
    endfunction

    function automatic word_t narrow_to_word(half_t h);
        return {{(WIDE_W-NARROW_W){1'b0}}, h};
    endfunction
endpackage

// File: rtl/sha2x_sigma.sv
`timescale 1ns/1ps
module sha2x_sigma
    import sha2x_pkg::*;
#(
    parameter bit ONE = 1'b0
) (
    input  word_t x_i,
    input  logic  wide_i,
    output word_t y_o
);
    // rotate / shift amounts picked by variant
    localparam int N_RA = ONE ? 17 : 7;
    localparam int N_RB = ONE ? 19 : 18;
    localparam int N_SH = ONE ? 10 : 3;
    localparam int W_RA = ONE ? 19 : 1;
    localparam int W_RB = ONE ? 61 : 8;
    localparam int W_SH = ONE ? 6  : 7;

    half_t lo;
    half_t n_y;
    word_t w_y;

    always_comb begin
        lo  = x_i[NARROW_W-1:0];
        n_y = rotr_n(lo, N_RA) ^ rotr_n(lo, N_RB) ^ (lo >> N_SH);
        w_y = rotr_w(x_i, W_RA) ^ rotr_w(x_i, W_RB) ^ (x_i >> W_SH);
        y_o = wide_i ? w_y : narrow_to_word(n_y);
    end
endmodule

// File: rtl/sha2x_modsum.sv
`timescale 1ns/1ps
module sha2x_modsum
    import sha2x_pkg::*;
(
    input  word_t a_i,
    input  word_t b_i,
    input  word_t c_i,
    input  word_t d_i,
    input  logic  wide_i,
    output word_t s_o
);
    word_t s_wide;
    half_t s_narrow;

    always_comb begin
        s_wide   = a_i + b_i + c_i + d_i;
        s_narrow = a_i[NARROW_W-1:0] + b_i[NARROW_W-1:0]
                 + c_i[NARROW_W-1:0] + d_i[NARROW_W-1:0];
        s_o      = wide_i ? s_wide : narrow_to_word(s_narrow);
    end
endmodule

// File: rtl/sha2x_sched_expander.sv
`timescale 1ns/1ps
module sha2x_sched_expander
    import sha2x_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_i,
    input  logic              load_i,
    input  logic [BLK_W-1:0]  block_i,
    input  logic              adv_i,
    output logic [WIDE_W-1:0] word_o,
    output logic              last_o
);
    sched_st_t          st_d, st_q;
    word_t              sig0, sig1, fresh;
    logic [CNT_W-1:0]   last_idx;
    logic               at_end;

    sha2x_sigma #(.ONE(1'b0)) i_sig0 (
        .x_i    (st_q.win[TAP_S0]),
        .wide_i (st_q.wide),
        .y_o    (sig0)
    );

    sha2x_sigma #(.ONE(1'b1)) i_sig1 (
        .x_i    (st_q.win[TAP_S1]),
        .wide_i (st_q.wide),
        .y_o    (sig1)
    );

    sha2x_modsum i_sum (
        .a_i    (sig1),
        .b_i    (st_q.win[TAP_MID]),
        .c_i    (sig0),
        .d_i    (st_q.win[0]),
        .wide_i (st_q.wide),
        .s_o    (fresh)
    );

    always_comb begin
        last_idx = st_q.wide ? CNT_W'(RND_WIDE - 1) : CNT_W'(RND_NARROW - 1);
        at_end   = st_q.active && (st_q.cnt == last_idx);
        st_d     = st_q;
        if (load_i) begin
            st_d.wide   = mode_i;
            st_d.active = 1'b1;
            st_d.cnt    = '0;
            for (int k = 0; k < WIN_D; k++) begin
                st_d.win[k] = mode_i ? word_t'(block_i[k*WIDE_W +: WIDE_W])
                                     : narrow_to_word(block_i[k*WIDE_W +: NARROW_W]);
            end
        end else if (adv_i && st_q.active && !at_end) begin
            for (int k = 0; k < WIN_D - 1; k++) begin
                st_d.win[k] = st_q.win[k+1];
            end
            st_d.win[WIN_D-1] = fresh;
            st_d.cnt          = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o = st_q.win[0];
    assign last_o = at_end;
endmodule

// File: rtl/sha2x_sched_chk.sv
`timescale 1ns/1ps
module sha2x_sched_chk
    import sha2x_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              mode_i,
    input logic              load_i,
    input logic [BLK_W-1:0]  block_i,
    input logic              adv_i,
    input logic [WIDE_W-1:0] word_o,
    input logic              last_o
);
    logic [7:0] steps_q;
    logic       loaded_q;
    logic       narrow_q;
    logic [7:0] limit;

    assign limit = narrow_q ? 8'(RND_NARROW - 1) : 8'(RND_WIDE - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            steps_q  <= '0;
            loaded_q <= 1'b0;
            narrow_q <= 1'b0;
        end else if (load_i) begin
            steps_q  <= '0;
            loaded_q <= 1'b1;
            narrow_q <= !mode_i;
        end else if (adv_i && loaded_q && !last_o) begin
            steps_q  <= steps_q + 8'd1;
        end
    end

    // R1: nothing leaves the block before the first load
    a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !loaded_q |-> (word_o == '0) && !last_o);

    // R2: first word after a load is block word 0, masked in narrow mode
    a_r2_load_word: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> word_o == ($past(mode_i) ? $past(block_i[WIDE_W-1:0])
                                            : {{NARROW_W{1'b0}}, $past(block_i[NARROW_W-1:0])}));

    // R2: narrow blocks keep the upper half clear
    a_r2_narrow_upper: assert property (@(posedge clk) disable iff (!rst_n)
        loaded_q && narrow_q |-> word_o[WIDE_W-1:NARROW_W] == '0);

    // R3: no strobe, no change
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i && !adv_i |=> $stable(word_o) && $stable(last_o));

    // R7: last flag marks exactly the final round of the captured mode
    a_r7_last_count: assert property (@(posedge clk) disable iff (!rst_n)
        loaded_q |-> last_o == (steps_q == limit));

    // R7: final word held against further advances
    a_r7_last_hold: assert property (@(posedge clk) disable iff (!rst_n)
        last_o && !load_i |=> last_o && $stable(word_o));

    // R9: a load always restarts the block
    a_r9_load_restart: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !last_o);
endmodule

bind sha2x_sched_expander sha2x_sched_chk i_sched_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_i  (mode_i),
    .load_i  (load_i),
    .block_i (block_i),
    .adv_i   (adv_i),
    .word_o  (word_o),
    .last_o  (last_o)
);

// File: tb/test_sha2x_sched_expander.sv
`timescale 1ns/1ps
module test_sha2x_sched_expander;
    typedef logic [63:0] w64_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_i = 1'b0;
    logic          load_i = 1'b0;
    logic [1023:0] block_i = '0;
    logic          adv_i = 1'b0;
    logic [63:0]   word_o;
    logic          last_o;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 0;

    w64_t exp_w [80];

    // {mode, gap, seed}
    localparam logic [65:0] VEC [6] = '{
        {1'b0, 1'b0, 64'h0123_4567_89AB_CDEF},
        {1'b1, 1'b0, 64'h0F1E_2D3C_4B5A_6978},
        {1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF},
        {1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF},
        {1'b0, 1'b0, 64'h8000_0000_8000_0001},
        {1'b1, 1'b1, 64'h8000_0000_0000_0001}
    };

    always #10 clk = ~clk;

    sha2x_sched_expander i_sha2x_sched_expander (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode_i),
        .load_i  (load_i),
        .block_i (block_i),
        .adv_i   (adv_i),
        .word_o  (word_o),
        .last_o  (last_o)
    );

    function automatic w64_t lane(w64_t seed, int k);
        w64_t v = seed ^ (64'h9E37_79B9_7F4A_7C15 * 64'(k + 1));
        return v ^ {v[31:0], v[63:32]};
    endfunction

    function automatic w64_t m_s0(w64_t x, bit wide);
        logic [31:0] t;
        if (wide) return {x[0], x[63:1]} ^ {x[7:0], x[63:8]} ^ (x >> 7);
        t = {x[6:0], x[31:7]} ^ {x[17:0], x[31:18]} ^ (x[31:0] >> 3);
        return {32'h0, t};
    endfunction

    function automatic w64_t m_s1(w64_t x, bit wide);
        logic [31:0] t;
        if (wide) return {x[18:0], x[63:19]} ^ {x[60:0], x[63:61]} ^ (x >> 6);
        t = {x[16:0], x[31:17]} ^ {x[18:0], x[31:19]} ^ (x[31:0] >> 10);
        return {32'h0, t};
    endfunction

    task automatic build(input bit wide, input w64_t seed);
        w64_t s;
        for (int k = 0; k < 16; k++) begin
            block_i[k*64 +: 64] = lane(seed, k);
            exp_w[k] = wide ? lane(seed, k) : {32'h0, lane(seed, k)[31:0]};
        end
        for (int j = 16; j < 80; j++) begin
            s = m_s1(exp_w[j-2], wide) + exp_w[j-7] + m_s0(exp_w[j-15], wide) + exp_w[j-16];
            exp_w[j] = wide ? s : {32'h0, s[31:0]};
        end
    endtask

    task automatic check(input w64_t act, input w64_t exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input bit l, input bit a);
        load_i = l;
        adv_i  = a;
        @(negedge clk);
        load_i = 1'b0;
        adv_i  = 1'b0;
    endtask

    task automatic run_block(input bit wide, input bit gap, input w64_t seed, input bit flip);
        int rounds = wide ? 80 : 64;
        string tag;
        build(wide, seed);
        mode_i = wide;
        step(1'b1, 1'b0);
        check(word_o, exp_w[0], "R2 word0");
        check(64'(last_o), 64'd0, "R7 last low after load");
        for (int j = 1; j < rounds; j++) begin
            if (flip) mode_i = ~mode_i;
            if (gap && (j % 5 == 0)) begin
                step(1'b0, 1'b0);
                check(word_o, exp_w[j-1], "R3 idle hold");
            end
            step(1'b0, 1'b1);
            if (flip) tag = "R8 mode flip ignored";
            else if (j < 16) tag = "R3 block word";
            else tag = wide ? "R6 R4 wide word" : "R5 R4 narrow word";
            check(word_o, exp_w[j], tag);
            check(64'(last_o), 64'(j == rounds - 1), "R7 last flag");
        end
        step(1'b0, 1'b1);
        check(word_o, exp_w[rounds-1], "R7 hold after last");
        check(64'(last_o), 64'd1, "R7 last stays high");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(word_o, 64'd0, "R1 reset word");
        check(64'(last_o), 64'd0, "R1 reset last");
        step(1'b0, 1'b1);
        check(word_o, 64'd0, "R1 advance before load");
        check(64'(last_o), 64'd0, "R1 last before load");

        for (int r = 0; r < 6; r++) begin
            run_block(VEC[r][65], VEC[r][64], VEC[r][63:0], 1'b0);
        end

        // R8: mode input toggles during a narrow block
        run_block(1'b0, 1'b0, 64'hDEAD_BEEF_0BAD_F00D, 1'b1);

        // R9: load collides with advance in the middle of a wide block
        build(1'b1, 64'h1357_9BDF_2468_ACE0);
        mode_i = 1'b1;
        step(1'b1, 1'b0);
        for (int j = 0; j < 20; j++) step(1'b0, 1'b1);
        check(word_o, exp_w[20], "R9 mid-block position");
        build(1'b0, 64'hCAFE_F00D_1234_5678);
        mode_i = 1'b0;
        step(1'b1, 1'b1);
        check(word_o, exp_w[0], "R9 load beats advance");
        check(64'(last_o), 64'd0, "R9 last cleared");
        step(1'b0, 1'b1);
        check(word_o, exp_w[1], "R9 resumes from new block");
        for (int j = 2; j < 64; j++) step(1'b0, 1'b1);
        check(word_o, exp_w[63], "R7 narrow final word");
        check(64'(last_o), 64'd1, "R7 narrow last");

        // R9: reload from the held final word
        build(1'b1, 64'h0000_0000_0000_0000);
        mode_i = 1'b1;
        step(1'b1, 1'b0);
        check(word_o, exp_w[0], "R9 reload after last");
        check(64'(last_o), 64'd0, "R9 last cleared on reload");

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #4ms;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule